// File: doc/BRIEF.md
# Rewindable Strobe-Driven FIFO with Half-Full Status

This block is a single-clock first-in/first-out buffer of 9-bit words. Two active-low strobes, one for writing and one for reading, are sampled on the system clock and turned into edge events. A word is stored when the write strobe returns high. A read has two steps. When the read strobe drops, the next word is placed on the output register. When the strobe returns high, the read completes and the read position moves on. Empty, Full and Half-Full status are active-low outputs.

A rewind input, also active-low, moves the read position back to the first word stored since reset. The same data can then be played out again, while the write position stays where it is. A mode input chooses whether Half-Full is driven or held inactive. It is held inactive when the block is not used as a single device or as part of a width-expanded group.

The depth is a power-of-two parameter. It is meant for 2048, 4096, 8192 or 16384 words. The width defaults to 9 bits, so one bit can carry parity or a tag.

Top module: `rt_fifo`

## Requirements
- R1: Words come out in the order they were written, with all 9 bits intact, including bit 8.
- R2: A write is accepted at the first clock edge that samples `wr_n` high after sampling it low. A read places the next word on `dout` at the first edge that samples `rd_n` low after high. That read completes, and the read position advances, at the first edge that samples `rd_n` high again.
- R3: A write and a read that complete at the same clock edge both take effect, and occupancy stays the same.
- R4: A write attempted while `full_n` is low is discarded. No stored word changes, and the discarded word is never read out.
- R5: A read attempted while `empty_n` is low is discarded. `dout` keeps its value and the read position does not move.
- R6: When `rewind_n` is sampled low, the read position returns to the first word written since reset, and the write position is unchanged. Occupancy becomes the number of words written since reset. This is valid while fewer than DEPTH words have been written.
- R7: With `single_mode` high, `half_n` is low exactly when occupancy is strictly greater than DEPTH/2.
- R8: With `single_mode` low, `half_n` is held high one edge after `single_mode` is sampled low.
- R9: `empty_n` is low exactly when occupancy is 0, and `full_n` is low exactly when occupancy is DEPTH. Both update at the same edge as the operation that changes occupancy.
- R10: With `rst_n` low, the buffer is emptied and both positions return to their start. `empty_n` is 0, `full_n` and `half_n` are 1, and `dout` is 0.
- R11: Strobe edges sampled while `rewind_n` is low are ignored. All flags are valid at the edge that samples the rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe; the word is stored on its rising edge |
| rd_n | input | 1 | Active-low read strobe; data is presented on its falling edge, and the read completes on its rising edge |
| rewind_n | input | 1 | Active-low request to rewind the read position |
| single_mode | input | 1 | High enables the half-full output |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when more than DEPTH/2 words are held and `single_mode` is high |

## Verification
Several properties are checked on every clock cycle:
- A write strobe seen while full leaves the write position alone.
- A read strobe seen while empty leaves the read position alone.
- A rewind always lands the read position at zero without moving the write position.
- A read and a write completing together keep occupancy unchanged.
- Half-Full stays inactive when the mode input is low.
- A falling write strobe never stores a word.

Only the directed scenarios can show the rest:
- The data order and the contents of every bit.
- That a word discarded while full never comes out.
- That a replay after a rewind returns exactly the earlier stream.
- The exact occupancy at which Half-Full and Full switch.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
    localparam int WORD_W = 9;

    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_ev_t;
endpackage

// File: rtl/rtf_strobe.sv
module rtf_strobe
    import rtf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    output strobe_ev_t ev
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = strobe_n;
        ev.rise = strobe_n & ~prev_q;
        ev.fall = ~strobe_n & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rtf_ram.sv
module rtf_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
    import rtf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    input  logic          rewind_n,
    input  logic          single_mode,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   count;
        logic          armed;
        logic          empty_n;
        logic          full_n;
        logic          half_n;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     wr_ok, rd_go, rd_done;

    always_comb begin
        st_d    = st_q;
        wr_ok   = 1'b0;
        rd_go   = 1'b0;
        rd_done = 1'b0;
        if (!rewind_n) begin
            st_d.rptr  = '0;
            st_d.count = {1'b0, st_q.wptr};
            st_d.armed = 1'b0;
        end else begin
            wr_ok   = wr_ev.rise && (st_q.count != FULL_CNT);
            rd_go   = rd_ev.fall && (st_q.count != '0) && !st_q.armed;
            rd_done = rd_ev.rise && st_q.armed;
            if (wr_ok) st_d.wptr = st_q.wptr + 1'b1;
            if (rd_go) st_d.armed = 1'b1;
            if (rd_done) begin
                st_d.rptr  = st_q.rptr + 1'b1;
                st_d.armed = 1'b0;
            end
            case ({wr_ok, rd_done})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
        st_d.empty_n = (st_d.count != '0);
        st_d.full_n  = (st_d.count != FULL_CNT);
        st_d.half_n  = !(single_mode && (st_d.count > HALF_CNT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wptr: '0, rptr: '0, count: '0, armed: 1'b0,
                      empty_n: 1'b0, full_n: 1'b1, half_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we    = wr_ok;
    assign ram_waddr = st_q.wptr;
    assign ram_re    = rd_go;
    assign ram_raddr = st_q.rptr;
    assign empty_n   = st_q.empty_n;
    assign full_n    = st_q.full_n;
    assign half_n    = st_q.half_n;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_ev.rise) |=> (st_q.wptr == $past(st_q.wptr)));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_ev.fall && rewind_n) |=> (st_q.rptr == $past(st_q.rptr)));

    // R6
    rewind_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> (st_q.rptr == '0) && (st_q.wptr == $past(st_q.wptr)));

    // R3
    both_ops_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_n && full_n && wr_ev.rise && rd_ev.rise && st_q.armed)
        |=> (st_q.count == $past(st_q.count)));

    // R8
    half_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !single_mode |=> half_n);

    // R2
    store_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev.fall |-> !ram_we);
endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
    import rtf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int W     = WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         rewind_n,
    input  logic         single_mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty_n,
    output logic         full_n,
    output logic         half_n
);
    strobe_ev_t    wr_ev, rd_ev;
    logic          ram_we, ram_re;
    logic [AW-1:0] ram_waddr, ram_raddr;

    rtf_strobe u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .ev(wr_ev));
    rtf_strobe u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .ev(rd_ev));

    rtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev),
        .rewind_n(rewind_n), .single_mode(single_mode),
        .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_re(ram_re), .ram_raddr(ram_raddr),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    rtf_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(din),
        .re(ram_re), .raddr(ram_raddr), .rdata(dout)
    );
endmodule

// File: tb/tb_rt_fifo.sv
module tb_rt_fifo;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rewind_n = 1'b1, single_mode = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       empty_n, full_n, half_n;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rt_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rewind_n(rewind_n),
        .single_mode(single_mode), .din(din), .dout(dout),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rewind_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [8:0] v);
        @(negedge clk); din = v; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pop(output logic [8:0] v);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); v = dout; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(empty_n == 1'b0, "R10 empty_n", empty_n, 0);
        check(full_n == 1'b1, "R10 full_n", full_n, 1);
        check(half_n == 1'b1, "R10 half_n", half_n, 1);
        check(dout == 9'h0, "R10 dout", dout, 0);
    endtask

    task automatic t_order();
        logic [8:0] v;
        do_reset();
        for (int i = 0; i < 5; i++) push(9'h100 | 9'(i * 37));
        check(empty_n == 1'b1, "R9 not empty after writes", empty_n, 1);
        for (int i = 0; i < 5; i++) begin
            pop(v);
            check(v == (9'h100 | 9'(i * 37)), "R1 order and bit 8", v, 9'h100 | 9'(i * 37));
        end
        check(empty_n == 1'b0, "R9 empty after drain", empty_n, 0);
    endtask

    task automatic t_strobe_timing();
        do_reset();
        @(negedge clk); din = 9'h0A5; wr_n = 1'b0;
        @(negedge clk);
        check(empty_n == 1'b0, "R2 no store on falling strobe", empty_n, 0);
        wr_n = 1'b1;
        @(negedge clk);
        check(empty_n == 1'b1, "R2 store on rising strobe", empty_n, 1);
        rd_n = 1'b0;
        @(negedge clk);
        check(dout == 9'h0A5, "R2 data on read fall", dout, 9'h0A5);
        check(empty_n == 1'b1, "R2 read not complete while low", empty_n, 1);
        rd_n = 1'b1;
        @(negedge clk);
        check(empty_n == 1'b0, "R2 read completes on rise", empty_n, 0);
    endtask

    task automatic t_full_half();
        logic [8:0] v;
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) push(9'(i + 1));
        check(half_n == 1'b1, "R7 half inactive at DEPTH/2", half_n, 1);
        push(9'(DEPTH / 2 + 1));
        check(half_n == 1'b0, "R7 half active above DEPTH/2", half_n, 0);
        for (int i = DEPTH / 2 + 1; i < DEPTH - 1; i++) push(9'(i + 1));
        check(full_n == 1'b1, "R9 not full at DEPTH-1", full_n, 1);
        push(9'(DEPTH));
        check(full_n == 1'b0, "R9 full at DEPTH", full_n, 0);
        push(9'h1FF);
        for (int i = 0; i < DEPTH; i++) begin
            pop(v);
            check(v == 9'(i + 1), "R4 contents unchanged by write while full", v, i + 1);
        end
        check(empty_n == 1'b0, "R4 discarded word absent", empty_n, 0);
    endtask

    task automatic t_empty_read();
        logic [8:0] v;
        do_reset();
        pop(v);
        check(dout == 9'h0, "R5 dout unchanged on empty read", dout, 0);
        check(empty_n == 1'b0, "R5 still empty", empty_n, 0);
        push(9'h1AB);
        pop(v);
        check(v == 9'h1AB, "R5 read position did not move", v, 9'h1AB);
    endtask

    task automatic t_simultaneous();
        logic [8:0] v;
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) push(9'(i + 20));
        @(negedge clk); din = 9'h155; wr_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); v = dout; wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        check(v == 9'd20, "R3 read data during simultaneous op", v, 20);
        check(half_n == 1'b1, "R3 occupancy unchanged", half_n, 1);
        push(9'h000);
        check(half_n == 1'b0, "R3 occupancy was DEPTH/2", half_n, 0);
    endtask

    task automatic t_rewind();
        logic [8:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) push(9'(i + 100));
        pop(v); pop(v);
        @(negedge clk); rewind_n = 1'b0; din = 9'h0EE; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); rewind_n = 1'b1;
        check(empty_n == 1'b1, "R11 flags valid after rewind", empty_n, 1);
        for (int i = 0; i < 4; i++) begin
            pop(v);
            check(v == 9'(i + 100), "R6 replay from start", v, i + 100);
        end
        check(empty_n == 1'b0, "R11 write during rewind ignored", empty_n, 0);
        push(9'h077);
        pop(v);
        check(v == 9'h077, "R6 write position kept", v, 9'h077);
    endtask

    task automatic t_mode();
        do_reset();
        for (int i = 0; i < DEPTH / 2 + 2; i++) push(9'(i));
        check(half_n == 1'b0, "R7 half active", half_n, 0);
        @(negedge clk); single_mode = 1'b0;
        @(negedge clk);
        check(half_n == 1'b1, "R8 half held in other mode", half_n, 1);
        single_mode = 1'b1;
        @(negedge clk);
        check(half_n == 1'b0, "R7 half back with mode", half_n, 0);
        do_reset();
        check(empty_n == 1'b0 && half_n == 1'b1, "R10 reset with data held", empty_n, 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_strobe_timing();
        t_full_half();
        t_empty_read();
        t_simultaneous();
        t_rewind();
        t_mode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule